// File: doc/BRIEF.md
# Lane Multiply-Add Unit

This unit is one lane of a vector multiply-add engine. Each cycle it can accept one operand set: three unsigned byte values from the scalar path (`s1`, `s2`, `s3`), one accumulator byte (`accIn`) and two 10-bit factors. It returns one signed sum. The sum is formed from a base term and one or two products.

In single-product form the unit computes base + first × `s2`. In dual-product form it computes base + first × factor1 + second × factor2. Small select fields choose the operands:

- **Base term:** zero, the accumulator, `s2`, half of `s2`, or `s3`. Bit 7 of the base can optionally be flipped.
- **First multiplicand:** `s1` or the difference `s1 - s3`.
- **Second multiplicand:** `s3` or the difference `s2 - s3`.
- **Factors:** either the signed 10-bit inputs, or fixed values taken from two mask bits. A set mask bit gives 0x100, which is unity with 8 fractional bits. A clear mask bit gives 0.

The unit is a two-stage pipeline. Stage one selects and registers the operands. Stage two multiplies, adds at full precision and registers a 24-bit two's-complement result. Saturation and rounding belong to the stage that follows this unit.

Top module: `lane_muladd`

## Requirements
- R1: With `dualMode`=0 the result is base + first × `s2`. The result does not depend on `dSel`, `f1`, `f2`, `maskMode`, `mask1` or `mask2`.
- R2: With `dualMode`=1 the result is base + first × factor1 + second × factor2. All products and sums are exact in a 24-bit two's-complement result.
- R3: `aSel` encodes the base term as follows: 0 gives zero, 1 gives `accIn`, 2 gives `s2`, 3 gives `s2` shifted right by one (floor), and 4 gives `s3`. The codes 5 to 7 give zero.
- R4: When `aXor`=1, bit 7 of the selected 8-bit base is inverted before the sum. The base stays unsigned (0..255).
- R5: `bSel`=0 selects `s1` as the first multiplicand. `bSel`=1 selects `s1 - s3` as a signed value in the range -255..255.
- R6: `dSel`=0 selects `s3` as the second multiplicand. `dSel`=1 selects `s2 - s3` as a signed value.
- R7: When `maskMode`=0, `f1` and `f2` are two's-complement 10-bit numbers. For example, 0x3FF is -1 and 0x200 is -512.
- R8: When `maskMode`=1, factor1 is 256 if `mask1`=1 and 0 otherwise. Factor2 follows `mask2` in the same way, and `f1` and `f2` are ignored.
- R9: `outValid` rises exactly two clock edges after the edge that samples `inValid`=1, with the matching result. Back-to-back inputs give back-to-back results in order.
- R10: After reset `outValid`=0 and `result`=0. While `outValid`=0 the result holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand set present this cycle |
| s1 | input | 8 | Scalar source 1, unsigned |
| s2 | input | 8 | Scalar source 2, unsigned |
| s3 | input | 8 | Scalar source 3, unsigned |
| accIn | input | 8 | Accumulator lane value, unsigned |
| f1 | input | 10 | Factor 1, two's complement |
| f2 | input | 10 | Factor 2, two's complement |
| mask1 | input | 1 | Mask bit for factor 1 in mask mode |
| mask2 | input | 1 | Mask bit for factor 2 in mask mode |
| aSel | input | 3 | Base term select |
| aXor | input | 1 | Invert bit 7 of the base |
| bSel | input | 1 | First multiplicand select |
| dSel | input | 1 | Second multiplicand select |
| dualMode | input | 1 | 0 for single product, 1 for dual product |
| maskMode | input | 1 | Take factors from the mask bits |
| outValid | output | 1 | Result valid |
| result | output | 24 | Signed sum |

## Verification
A wrong operand select, a lost sign extension on a factor or difference, or a wrong mask constant shows as a wrong `result` on the `outValid` cycle. That is two edges after the input, and it affects only the inputs that exercise that path. Each operand encoding is therefore driven in a setting where it changes the sum. A stuck or skewed valid stage shows at once as a result arriving a cycle early or late, or missing entirely. A stage that reloads when it should not shows as a result that changes during idle cycles.

// File: rtl/lane_muladd_pkg.sv
package lane_muladd_pkg;

  // Base term encodings
  typedef enum logic [2:0] {
    BASE_ZERO  = 3'd0,
    BASE_ACC   = 3'd1,
    BASE_S2    = 3'd2,
    BASE_S2HLF = 3'd3,
    BASE_S3    = 3'd4
  } baseSrc_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadOperands;
    logic loadResult;
  } madStrobes_t;

endpackage

// File: rtl/lane_muladd_ctrl.sv
module lane_muladd_ctrl
  import lane_muladd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output madStrobes_t strobes,
  output logic        outValid
);

  logic stage1Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
    end
  end

  always_comb begin
    strobes.loadOperands = inValid;
    strobes.loadResult   = stage1Valid;
  end

  // R9: an accepted input appears at the output two edges later
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);

  // R9: no output without an input two edges earlier
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ##1 !outValid);

endmodule

// File: rtl/lane_muladd_dp.sv
module lane_muladd_dp
  import lane_muladd_pkg::*;
#(
  parameter int DW = 8,
  parameter int FW = 10,
  parameter int RW = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  madStrobes_t   strobes,
  input  logic [DW-1:0] s1,
  input  logic [DW-1:0] s2,
  input  logic [DW-1:0] s3,
  input  logic [DW-1:0] accIn,
  input  logic [FW-1:0] f1,
  input  logic [FW-1:0] f2,
  input  logic          mask1,
  input  logic          mask2,
  input  logic [2:0]    aSel,
  input  logic          aXor,
  input  logic          bSel,
  input  logic          dSel,
  input  logic          dualMode,
  input  logic          maskMode,
  output logic [RW-1:0] result
);

  localparam int DIFW  = DW + 1;                 // signed difference width
  localparam int OPW   = FW + 1;                 // signed factor operand width
  localparam int PW    = DIFW + OPW;             // product width
  localparam int TERMS = 2;
  localparam logic [OPW-1:0] UNITY = OPW'(1) << DW;
  localparam logic [DW-1:0]  FLIP  = DW'(1) << (DW - 1);

  // ---------------- stage 1: operand selection ----------------
  logic [DW-1:0]          baseN;
  logic signed [DIFW-1:0] mulXN [TERMS];
  logic signed [OPW-1:0]  mulYN [TERMS];
  logic signed [OPW-1:0]  fac1, fac2;
  logic signed [DIFW-1:0] s1e, s2e, s3e;

  always_comb begin
    s1e = {1'b0, s1};
    s2e = {1'b0, s2};
    s3e = {1'b0, s3};

    unique case (baseSrc_t'(aSel))
      BASE_ACC:   baseN = accIn;
      BASE_S2:    baseN = s2;
      BASE_S2HLF: baseN = {1'b0, s2[DW-1:1]};
      BASE_S3:    baseN = s3;
      default:    baseN = '0;
    endcase
    if (aXor) baseN = baseN ^ FLIP;

    if (maskMode) begin
      fac1 = mask1 ? UNITY : '0;
      fac2 = mask2 ? UNITY : '0;
    end else begin
      fac1 = {f1[FW-1], f1};
      fac2 = {f2[FW-1], f2};
    end

    mulXN[0] = bSel ? (s1e - s3e) : s1e;
    mulYN[0] = dualMode ? fac1 : OPW'(s2e);
    mulXN[1] = dSel ? (s2e - s3e) : s3e;
    mulYN[1] = dualMode ? fac2 : '0;
  end

  logic [DW-1:0]          baseQ;
  logic signed [DIFW-1:0] mulXQ [TERMS];
  logic signed [OPW-1:0]  mulYQ [TERMS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
    end else if (strobes.loadOperands) begin
      baseQ <= baseN;
    end
  end

  // ---------------- stage 2: products and sum ----------------
  logic signed [RW-1:0] termExt [TERMS];

  for (genvar t = 0; t < TERMS; t++) begin : gTerm
    logic signed [PW-1:0] prod;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        mulXQ[t] <= '0;
        mulYQ[t] <= '0;
      end else if (strobes.loadOperands) begin
        mulXQ[t] <= mulXN[t];
        mulYQ[t] <= mulYN[t];
      end
    end

    always_comb begin
      prod       = mulXQ[t] * mulYQ[t];
      termExt[t] = {{(RW-PW){prod[PW-1]}}, prod};
    end
  end

  logic signed [RW-1:0] sumN;

  always_comb begin
    sumN = {{(RW-DW){1'b0}}, baseQ};
    for (int t = 0; t < TERMS; t++) sumN = sumN + termExt[t];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
    end else if (strobes.loadResult) begin
      result <= sumN;
    end
  end

  // R10: the result register moves only on a result strobe
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadResult |=> $stable(result));

  // R8: in mask mode a registered factor is either zero or unity
  assert_mask_factor_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadOperands && maskMode && dualMode) |=>
      ((mulYQ[0] == '0 || mulYQ[0] == UNITY) && (mulYQ[1] == '0 || mulYQ[1] == UNITY)));

  // R1: single-product form loads no second factor
  assert_single_no_second_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadOperands && !dualMode) |=> (mulYQ[1] == '0));

  // R2: a result that is loaded is fully known
  assert_result_known_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadResult |=> !$isunknown(result));

endmodule

// File: rtl/lane_muladd.sv
module lane_muladd
  import lane_muladd_pkg::*;
#(
  parameter int DW = 8,
  parameter int FW = 10,
  parameter int RW = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [DW-1:0] s1,
  input  logic [DW-1:0] s2,
  input  logic [DW-1:0] s3,
  input  logic [DW-1:0] accIn,
  input  logic [FW-1:0] f1,
  input  logic [FW-1:0] f2,
  input  logic          mask1,
  input  logic          mask2,
  input  logic [2:0]    aSel,
  input  logic          aXor,
  input  logic          bSel,
  input  logic          dSel,
  input  logic          dualMode,
  input  logic          maskMode,
  output logic          outValid,
  output logic [RW-1:0] result
);

  madStrobes_t strobes;

  lane_muladd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  lane_muladd_dp #(.DW(DW), .FW(FW), .RW(RW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .s1       (s1),
    .s2       (s2),
    .s3       (s3),
    .accIn    (accIn),
    .f1       (f1),
    .f2       (f2),
    .mask1    (mask1),
    .mask2    (mask2),
    .aSel     (aSel),
    .aXor     (aXor),
    .bSel     (bSel),
    .dSel     (dSel),
    .dualMode (dualMode),
    .maskMode (maskMode),
    .result   (result)
  );

endmodule

// File: tb/sim_lane_muladd.sv
module sim_lane_muladd;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  s1 = '0, s2 = '0, s3 = '0, accIn = '0;
  logic [9:0]  f1 = '0, f2 = '0;
  logic        mask1 = 1'b0, mask2 = 1'b0;
  logic [2:0]  aSel = '0;
  logic        aXor = 1'b0, bSel = 1'b0, dSel = 1'b0, dualMode = 1'b0, maskMode = 1'b0;
  logic        outValid;
  logic [23:0] result;

  always #4 clk = ~clk;   // 125 MHz

  lane_muladd u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .s1(s1), .s2(s2), .s3(s3), .accIn(accIn), .f1(f1), .f2(f2),
    .mask1(mask1), .mask2(mask2), .aSel(aSel), .aXor(aXor),
    .bSel(bSel), .dSel(dSel), .dualMode(dualMode), .maskMode(maskMode),
    .outValid(outValid), .result(result)
  );

  typedef struct {
    int    expVal;
    int    dueCycle;
    string tag;
  } item_t;

  item_t queueExp[$];
  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    lastExp = 0;
  bit    monitorOn = 1'b0;
  bit    finished = 1'b0;

  always_ff @(posedge clk) cyc <= cyc + 1;

  function automatic int sext10(input logic [9:0] v);
    return (v >= 10'd512) ? int'(v) - 1024 : int'(v);
  endfunction

  function automatic int model(
    input int a1, input int a2, input int a3, input int acc,
    input logic [9:0] g1, input logic [9:0] g2, input bit m1, input bit m2,
    input int as, input bit ax, input bit bs, input bit ds, input bit dual, input bit msk);
    int base, b, d, k1, k2;
    case (as)
      1: base = acc;
      2: base = a2;
      3: base = a2 / 2;
      4: base = a3;
      default: base = 0;
    endcase
    if (ax) base = base ^ 128;
    b  = bs ? a1 - a3 : a1;
    d  = ds ? a2 - a3 : a3;
    k1 = msk ? (m1 ? 256 : 0) : sext10(g1);
    k2 = msk ? (m2 ? 256 : 0) : sext10(g2);
    return dual ? base + b * k1 + d * k2 : base + b * a2;
  endfunction

  task automatic drive(
    input int a1, input int a2, input int a3, input int acc,
    input logic [9:0] g1, input logic [9:0] g2, input bit m1, input bit m2,
    input int as, input bit ax, input bit bs, input bit ds, input bit dual, input bit msk,
    input string tag);
    item_t it;
    @(negedge clk);
    inValid = 1'b1;
    s1 = 8'(a1); s2 = 8'(a2); s3 = 8'(a3); accIn = 8'(acc);
    f1 = g1; f2 = g2; mask1 = m1; mask2 = m2;
    aSel = 3'(as); aXor = ax; bSel = bs; dSel = ds; dualMode = dual; maskMode = msk;
    it.expVal   = model(a1, a2, a3, acc, g1, g2, m1, m2, as, ax, bs, ds, dual, msk);
    it.dueCycle = cyc + 2;
    it.tag      = tag;
    queueExp.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      s1 = 8'hA5; f1 = 10'h155; aSel = 3'd1;   // noise while idle
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (monitorOn && rstN) begin
      if (outValid) begin
        checks++;
        if (queueExp.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected outValid: actual result=%0d expected no output", $signed(result));
        end else begin
          item_t it;
          it = queueExp.pop_front();
          if (int'($signed(result)) != it.expVal || cyc != it.dueCycle) begin
            errors++;
            $display("FAIL %s: actual %0d @cycle %0d expected %0d @cycle %0d",
                     it.tag, $signed(result), cyc, it.expVal, it.dueCycle);
          end
          lastExp = it.expVal;
        end
      end else begin
        if (queueExp.size() != 0 && queueExp[0].dueCycle <= cyc) begin
          checks++;
          errors++;
          $display("FAIL R9 missing outValid for %s: actual 0 expected 1", queueExp[0].tag);
          void'(queueExp.pop_front());
        end
        checks++;
        if (int'($signed(result)) != lastExp) begin
          errors++;
          $display("FAIL R10 hold while idle: actual %0d expected %0d", $signed(result), lastExp);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || result !== 24'd0) begin
      errors++;
      $display("FAIL R10 reset state: actual outValid=%b result=%0h expected 0/0", outValid, result);
    end
    rstN = 1'b1;
    monitorOn = 1'b1;

    // R1 single product, every base code (R3) and xor (R4)
    drive(10, 20, 3, 7, 10'h3FF, 10'h100, 1, 1, 0, 0, 0, 0, 0, 0, "R1 single base zero");
    drive(10, 20, 3, 7, 10'h000, 10'h000, 0, 0, 1, 0, 0, 0, 0, 0, "R3 base acc");
    drive(10, 21, 3, 7, 10'h000, 10'h000, 0, 0, 2, 0, 0, 0, 0, 0, "R3 base s2");
    drive(10, 21, 3, 7, 10'h000, 10'h000, 0, 0, 3, 0, 0, 0, 0, 0, "R3 base s2 half");
    drive(10, 21, 99, 7, 10'h000, 10'h000, 0, 0, 4, 0, 0, 0, 0, 0, "R3 base s3");
    drive(10, 21, 99, 7, 10'h000, 10'h000, 0, 0, 5, 0, 0, 0, 0, 0, "R3 base code 5");
    drive(10, 21, 99, 7, 10'h000, 10'h000, 0, 0, 7, 0, 0, 0, 0, 0, "R3 base code 7");
    drive(0, 0, 0, 200, 10'h000, 10'h000, 0, 0, 1, 1, 0, 0, 0, 0, "R4 xor clears bit7");
    drive(0, 0, 0, 5, 10'h000, 10'h000, 0, 0, 1, 1, 0, 0, 0, 0, "R4 xor sets bit7");
    drive(0, 0, 0, 0, 10'h000, 10'h000, 0, 0, 0, 1, 0, 0, 0, 0, "R4 xor on zero base");
    // R5 difference, negative
    drive(3, 255, 200, 0, 10'h000, 10'h000, 0, 0, 0, 0, 1, 0, 0, 0, "R5 s1-s3 negative");
    drive(0, 255, 255, 0, 10'h000, 10'h000, 0, 0, 2, 0, 1, 0, 0, 0, "R5 s1-s3 min");
    // R1: d/f/mask inputs do not matter in single mode
    drive(9, 9, 9, 9, 10'h1FF, 10'h2AA, 1, 1, 1, 0, 0, 1, 0, 1, "R1 single ignores d/f/mask");
    idle(3);
    // R2 / R6 / R7 dual with signed factors
    drive(255, 0, 255, 0, 10'h1FF, 10'h1FF, 0, 0, 0, 0, 0, 0, 1, 0, "R2 dual max positive");
    drive(255, 0, 255, 0, 10'h200, 10'h200, 0, 0, 0, 0, 0, 0, 1, 0, "R7 factor -512");
    drive(5, 6, 7, 0, 10'h3FF, 10'h3FE, 0, 0, 1, 0, 0, 0, 1, 0, "R7 factors -1 -2");
    drive(5, 6, 200, 0, 10'h010, 10'h020, 0, 0, 0, 0, 0, 1, 1, 0, "R6 s2-s3 negative");
    drive(5, 250, 2, 0, 10'h010, 10'h020, 0, 0, 0, 0, 1, 1, 1, 0, "R6 s2-s3 with R5 diff");
    // R8 mask mode
    drive(12, 34, 56, 0, 10'h3FF, 10'h3FF, 1, 0, 0, 0, 0, 0, 1, 1, "R8 mask 1/0");
    drive(12, 34, 56, 0, 10'h3FF, 10'h3FF, 0, 1, 0, 0, 0, 0, 1, 1, "R8 mask 0/1");
    drive(12, 34, 56, 77, 10'h123, 10'h321, 1, 1, 1, 1, 1, 1, 1, 1, "R8 mask 1/1");
    drive(12, 34, 56, 77, 10'h123, 10'h321, 0, 0, 1, 0, 1, 1, 1, 1, "R8 mask 0/0");
    idle(2);
    // R9 random back-to-back stream
    for (int i = 0; i < 200; i++) begin
      drive($urandom_range(255), $urandom_range(255), $urandom_range(255), $urandom_range(255),
            10'($urandom), 10'($urandom), 1'($urandom), 1'($urandom),
            $urandom_range(7), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), "R9 random stream");
      if ((i % 17) == 16) idle(1);
    end
    idle(5);
    checks++;
    if (queueExp.size() != 0) begin
      errors++;
      $display("FAIL R9 outstanding results: actual %0d expected 0", queueExp.size());
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule